// File: doc/BRIEF.md
# Serial Core Run-State Controller

This block sits beside a serial bus engine and decides whether that engine is held in reset, running, or paused. A host reaches it through a plain register port: it writes a requested state code, may strike a software-reset register, and reads back the current state, a valid flag and a ready-for-bus-activity flag. Any accepted state change takes a fixed settling time. During that time the valid flag is low. The new state shows in the read-back only when the valid flag returns. Software therefore polls for valid together with the code it asked for.

The block also keeps five sticky error flags raised by the engine. Each flag has its own enable. Together they drive one level-sensitive interrupt line. The host clears flags by writing ones to them. Two other actions also clear every flag: a software reset, and an accepted request for the reset state. This lets a handler that owns a single level interrupt drop the line.

Register map (word addresses on `regAddr`): 0 state, 1 software reset, 2 error flags, 3 error enables. Any other address reads zero.

Top module: `run_state_ctrl`

## Requirements
- R1: After reset, the state register reads 0x14: code reset (0) in bits 1:0, the valid flag set in bit 2, and the ready flag set in bit 4. The error flags read 0, the enables read 0 and `irq` is low.
- R2: State codes in bits 1:0 are 0 = reset, 1 = run and 3 = pause. An accepted write drives valid (bit 2) low for exactly SETTLE_CYCLES clocks (default 4). While valid is low, bits 1:0 keep the previous state. When valid returns to 1, bits 1:0 show the new state.
- R3: A request for pause (3) is accepted only while the current state is run. From any other state it is ignored: valid stays high and the state is unchanged.
- R4: A write of the undefined code 2 is ignored and the current state is kept.
- R5: A state write arriving while valid is low is ignored. The transition already in progress completes to its own target.
- R6: The ready flag (bit 4) is set only while valid is high and the state is reset or run. It is clear while settling and while in pause.
- R7: Writing 1 in bit 0 of the software-reset register forces state reset with valid set on the next clock, and clears all error flags. Writing 0 there has no effect.
- R8: `errSet[i]` sets sticky error flag bit i+2 of the error register (bits 6:2). Writing 1 to a bit of the error register clears that bit. When a set and a clear hit the same bit in the same clock, the set wins.
- R9: Error-enable bits 6:2 are read/write and other bits read 0. `irq` is high exactly while some flag and its enable are both set. It rises in the clock after the `errSet` pulse is sampled.
- R10: An accepted write of state code 0 clears all error flags at the clock that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe, sampled at the clock edge |
| regAddr | input | ADDR_W | Register word address for both read and write |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Combinational read data for `regAddr` |
| errSet | input | ERR_W | Error events from the engine, one per flag |
| irq | output | 1 | Level interrupt: any enabled error flag is set |

## Verification
A stuck or miscounted settle counter shows at the state register within a few clocks of an accepted write. The valid flag either stays low past the fourth clock or returns early, and bits 1:0 either jump before valid or never change. A wrong acceptance decision shows at once: valid does not fall for a legal request, or falls for pause from reset, for code 2, or for a request made mid-settle. Faults in the flag logic appear in the clock after the event, either in the error register or on `irq`. That includes losing a set that collides with a clear, or failing to clear on software reset or on a reset-state request.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_UNDEF = 2'd2,
    ST_PAUSE = 2'd3
  } runState_t;

  // strobes issued by the control to the flag datapath
  typedef struct packed {
    logic clearAll;  // software reset or accepted reset-state request
    logic w1cWrite;  // write to the error register
    logic enWrite;   // write to the enable register
  } dpStrobe_t;

  localparam int unsigned ADDR_STATE = 0;
  localparam int unsigned ADDR_SWRST = 1;
  localparam int unsigned ADDR_ERR   = 2;
  localparam int unsigned ADDR_ERREN = 3;

  localparam int unsigned VALID_BIT = 2;
  localparam int unsigned READY_BIT = 4;
  localparam int unsigned ERR_LSB   = 2;

endpackage

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        reqCode,
  input  logic              swBit,
  output logic [1:0]        curState,
  output logic              stateValid,
  output logic              masterReady,
  output dpStrobe_t         strobe
);

  localparam int unsigned CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  runState_t        stateQ;
  runState_t        targetQ;
  logic             busyQ;
  logic [CNT_W-1:0] cntQ;

  logic stateSel;
  logic legalReq;
  logic accept;
  logic swReset;

  assign stateSel = regWe && (regAddr == ADDR_W'(ADDR_STATE));
  assign swReset  = regWe && (regAddr == ADDR_W'(ADDR_SWRST)) && swBit;

  always_comb begin
    unique case (reqCode)
      2'd0:    legalReq = 1'b1;
      2'd1:    legalReq = 1'b1;
      2'd3:    legalReq = (stateQ == ST_RUN);
      default: legalReq = 1'b0;
    endcase
  end

  assign accept = stateSel && !busyQ && legalReq && !swReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_RESET;
      targetQ <= ST_RESET;
      busyQ   <= 1'b0;
      cntQ    <= '0;
    end else if (swReset) begin
      stateQ <= ST_RESET;
      busyQ  <= 1'b0;
      cntQ   <= '0;
    end else if (accept) begin
      busyQ   <= 1'b1;
      cntQ    <= CNT_LOAD;
      targetQ <= runState_t'(reqCode);
    end else if (busyQ) begin
      if (cntQ == '0) begin
        busyQ  <= 1'b0;
        stateQ <= targetQ;
      end else begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  assign curState    = stateQ;
  assign stateValid  = !busyQ;
  assign masterReady = !busyQ && (stateQ != ST_PAUSE);

  assign strobe.clearAll = swReset || (accept && (reqCode == 2'd0));
  assign strobe.w1cWrite = regWe && (regAddr == ADDR_W'(ADDR_ERR));
  assign strobe.enWrite  = regWe && (regAddr == ADDR_W'(ADDR_ERREN));

endmodule

// File: rtl/rsc_datapath.sv
module rsc_datapath
  import rsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ERR_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ERR_W-1:0]  wMask,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [ERR_W-1:0]  errSet,
  input  logic [1:0]        curState,
  input  logic              stateValid,
  input  logic              masterReady,
  output logic [DATA_W-1:0] regRdata,
  output logic [ERR_W-1:0]  errFlags,
  output logic [ERR_W-1:0]  errEn,
  output logic              irq
);

  // one sticky flop per flag; a new event always outranks any clear
  for (genvar i = 0; i < ERR_W; i++) begin : g_flag
    logic clrHit;
    assign clrHit = strobe.clearAll || (strobe.w1cWrite && wMask[i]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          errFlags[i] <= 1'b0;
      else if (errSet[i]) errFlags[i] <= 1'b1;
      else if (clrHit)    errFlags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               errEn <= '0;
    else if (strobe.enWrite) errEn <= wMask;
  end

  assign irq = |(errFlags & errEn);

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_W'(ADDR_STATE)) begin
      regRdata[1:0]       = curState;
      regRdata[VALID_BIT] = stateValid;
      regRdata[READY_BIT] = masterReady;
    end else if (regAddr == ADDR_W'(ADDR_ERR)) begin
      regRdata[ERR_LSB +: ERR_W] = errFlags;
    end else if (regAddr == ADDR_W'(ADDR_ERREN)) begin
      regRdata[ERR_LSB +: ERR_W] = errEn;
    end
  end

endmodule

// File: rtl/run_state_ctrl.sv
module run_state_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned ERR_W         = 5,
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [ERR_W-1:0]  errSet,
  output logic              irq
);

  logic [1:0]       curState;
  logic             stateValid;
  logic             masterReady;
  dpStrobe_t        strobe;
  logic [ERR_W-1:0] errFlags;
  logic [ERR_W-1:0] errEn;

  rsc_ctrl #(
    .ADDR_W(ADDR_W),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .regWe(regWe),
    .regAddr(regAddr),
    .reqCode(regWdata[1:0]),
    .swBit(regWdata[0]),
    .curState(curState),
    .stateValid(stateValid),
    .masterReady(masterReady),
    .strobe(strobe)
  );

  rsc_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .ERR_W(ERR_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .wMask(regWdata[ERR_LSB +: ERR_W]),
    .regAddr(regAddr),
    .errSet(errSet),
    .curState(curState),
    .stateValid(stateValid),
    .masterReady(masterReady),
    .regRdata(regRdata),
    .errFlags(errFlags),
    .errEn(errEn),
    .irq(irq)
  );

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned ERR_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              swBit,
  input logic [ERR_W-1:0]  errSet,
  input logic              irq,
  input logic [1:0]        curState,
  input logic              stateValid,
  input logic [ERR_W-1:0]  errEn
);

  // R2: the visible state only moves in the cycle valid is high
  assert_state_moves_with_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curState) |-> stateValid);

  // R2: a settle window lasts longer than one clock
  assert_settle_not_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stateValid) |=> !stateValid);

  // R3: pause is reached only from run
  assert_pause_from_run_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(curState) && curState == 2'd3) |-> $past(curState) == 2'd1);

  // R4: the undefined code is never the current state
  assert_no_undef_state_R4: assert property (@(posedge clk) disable iff (!rstN)
    curState != 2'd2);

  // R7: software reset lands in reset with valid set
  assert_swreset_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(1) && swBit) |=> (curState == 2'd0 && stateValid));

  // R9: an enabled error event raises irq next clock
  assert_irq_follows_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((|(errSet & errEn)) && !(regWe && regAddr == ADDR_W'(3))) |=> irq);

endmodule

bind run_state_ctrl rsc_checker #(
  .ADDR_W(ADDR_W),
  .ERR_W(ERR_W)
) u_rscChecker (
  .clk(clk),
  .rstN(rstN),
  .regWe(regWe),
  .regAddr(regAddr),
  .swBit(regWdata[0]),
  .errSet(errSet),
  .irq(irq),
  .curState(curState),
  .stateValid(stateValid),
  .errEn(errEn)
);

// File: tb/run_state_ctrl_bench.sv
module run_state_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [4:0]  errSet = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  run_state_ctrl u_run_state_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .errSet(errSet), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseErr(input logic [4:0] v);
    @(negedge clk);
    errSet = v;
    @(negedge clk);
    errSet = '0;
  endtask

  task automatic gotoState(input logic [1:0] s);
    wr(4'd0, {30'd0, s});
    idle(5);
  endtask

  // after a write returns: 4 reads with valid low and old code, then new value
  task automatic settleCheck(input string tag, input logic [31:0] lowVal, input logic [31:0] newVal);
    logic [31:0] v;
    rd(4'd0, v); check({tag, " settle0"}, v, lowVal);
    for (int i = 1; i < 4; i++) begin
      @(negedge clk); rd(4'd0, v); check({tag, " settle"}, v, lowVal);
    end
    @(negedge clk); rd(4'd0, v); check({tag, " done"}, v, newVal);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(4'd0, v); check("R1 state", v, 32'h14);
    rd(4'd2, v); check("R1 flags", v, 32'h0);
    rd(4'd3, v); check("R1 enables", v, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic testRunPause();
    wr(4'd0, 32'd1); settleCheck("R2 R6 to run", 32'h00, 32'h15);
    wr(4'd0, 32'd3); settleCheck("R3 R6 to pause", 32'h01, 32'h07);
    wr(4'd0, 32'd1); settleCheck("R2 pause to run", 32'h03, 32'h15);
  endtask

  task automatic testPauseFromReset();
    logic [31:0] v;
    gotoState(2'd0);
    rd(4'd0, v); check("R3 in reset", v, 32'h14);
    wr(4'd0, 32'd3);
    rd(4'd0, v); check("R3 pause from reset no settle", v, 32'h14);
    idle(5);
    rd(4'd0, v); check("R3 pause from reset kept", v, 32'h14);
  endtask

  task automatic testUndef();
    logic [31:0] v;
    gotoState(2'd1);
    wr(4'd0, 32'd2);
    rd(4'd0, v); check("R4 code2 no settle", v, 32'h15);
    idle(5);
    rd(4'd0, v); check("R4 code2 kept", v, 32'h15);
  endtask

  task automatic testBusyWrite();
    logic [31:0] v;
    gotoState(2'd1);
    wr(4'd0, 32'd0);
    wr(4'd0, 32'd1);
    rd(4'd0, v); check("R5 still settling", v, 32'h01);
    idle(6);
    rd(4'd0, v); check("R5 first target wins", v, 32'h14);
  endtask

  task automatic testSwReset();
    logic [31:0] v;
    gotoState(2'd1);
    pulseErr(5'b00011);
    wr(4'd1, 32'd1);
    rd(4'd0, v); check("R7 swreset state", v, 32'h14);
    rd(4'd2, v); check("R7 swreset flags", v, 32'h0);
    gotoState(2'd1);
    wr(4'd1, 32'd0);
    rd(4'd0, v); check("R7 swreset zero ignored", v, 32'h15);
  endtask

  task automatic testFlags();
    logic [31:0] v;
    pulseErr(5'b00101);
    rd(4'd2, v); check("R8 sticky set", v, 32'h14);
    wr(4'd2, 32'h04);
    rd(4'd2, v); check("R8 w1c", v, 32'h10);
    @(negedge clk);
    errSet = 5'b00010; regWe = 1'b1; regAddr = 4'd2; regWdata = 32'h08;
    @(negedge clk);
    errSet = '0; regWe = 1'b0; regWdata = '0;
    rd(4'd2, v); check("R8 set beats clear", v, 32'h18);
    wr(4'd2, 32'h7C);
    rd(4'd2, v); check("R8 clear all", v, 32'h0);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    wr(4'd3, 32'hFF);
    rd(4'd3, v); check("R9 enable field", v, 32'h7C);
    wr(4'd3, 32'h08);
    pulseErr(5'b00100);
    check("R9 disabled flag no irq", {31'd0, irq}, 32'h0);
    pulseErr(5'b00010);
    check("R9 enabled flag irq", {31'd0, irq}, 32'h1);
    wr(4'd2, 32'h08);
    check("R9 irq drops on clear", {31'd0, irq}, 32'h0);
    wr(4'd2, 32'h7C);
  endtask

  task automatic testResetReqClears();
    logic [31:0] v;
    wr(4'd3, 32'h7C);
    gotoState(2'd1);
    pulseErr(5'b11111);
    rd(4'd2, v); check("R10 flags set", v, 32'h7C);
    check("R10 irq high", {31'd0, irq}, 32'h1);
    wr(4'd0, 32'd0);
    rd(4'd2, v); check("R10 flags cleared", v, 32'h0);
    check("R10 irq low", {31'd0, irq}, 32'h0);
    idle(5);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testRunPause();
    testPauseFromReset();
    testUndef();
    testBusyWrite();
    testSwReset();
    testFlags();
    testIrq();
    testResetReqClears();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule